// File: doc/BRIEF.md
# Relative Branch Target Unit

This block works out where a conditional relative branch goes and how many extra cycles it costs. The caller supplies the 24-bit program counter of the branch, its 8-bit signed displacement, a flag that says whether the branch condition already evaluated true, and the emulation-mode flag. Selecting and testing the condition code, and fetching the opcode, happen outside this block.

The program counter is split into an 8-bit bank and a 16-bit offset. The fall-through address is the offset plus two. A taken branch adds the sign-extended displacement to that fall-through address. All offset arithmetic wraps modulo 2^16, and the bank byte is always passed through unchanged. A taken branch costs one extra cycle. In emulation mode it costs a second extra cycle when the target lies in a different 256-byte page from the fall-through address.

A request is sampled on a rising clock edge while `reqValid` is high. The results appear on registered outputs in the next cycle, together with a one-cycle `outValid` strobe. The outputs keep their values until the next request.

Top module: `rel_branch_unit`

## Requirements
- R1: While reset is asserted and after reset is released, `outValid` is 0, `nextPc` is 0 and `extraCycles` is 0 until the first request is taken.
- R2: `outValid` is 1 in the cycle after an edge at which `reqValid` was 1. It is 0 in the cycle after an edge at which `reqValid` was 0.
- R3: For an untaken branch (`condTrue`=0), `nextPc` is the bank of `pc` concatenated with (`pc`[15:0] + 2) mod 2^16, and `extraCycles` is 0.
- R4: For a taken branch, `nextPc`[15:0] is (`pc`[15:0] + 2 + sign-extended `disp`) mod 2^16. Bit 7 of `disp` is its sign bit.
- R5: A taken branch gives `extraCycles` = 1 when `emuMode` is 0, or when target bits 15:8 equal bits 15:8 of `pc`[15:0] + 2.
- R6: A taken branch gives `extraCycles` = 2 when `emuMode` is 1 and target bits 15:8 differ from bits 15:8 of `pc`[15:0] + 2.
- R7: `nextPc`[23:16` always equals `pc`[23:16] of the request, even when the offset arithmetic wraps past 0xFFFF or below 0x0000.
- R8: In cycles without a request, `nextPc` and `extraCycles` keep their last values, whatever is driven on `pc`, `disp`, `condTrue` and `emuMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| pc | input | 24 | Program counter of the branch: bank in 23:16, offset in 15:0 |
| disp | input | 8 | Signed two's-complement displacement |
| condTrue | input | 1 | Branch condition result; 1 means taken |
| emuMode | input | 1 | Emulation flag; enables the page-cross penalty |
| outValid | output | 1 | One-cycle strobe marking a new result |
| nextPc | output | 24 | Next program counter |
| extraCycles | output | 2 | Extra cycles caused by the branch, 0 to 2 |

## Verification
The assertions assume that every input is a known value whenever `reqValid` is high, and that reset lasts at least one clock edge. They place no limit on how often requests arrive, so back-to-back requests are allowed. The stimulus is driven on the falling edge, so inputs are stable around each rising edge. It mixes random banks, offsets and displacements, often placed near page and bank edges, with directed cases for bank wrap, negative wrap and page crossing in both modes. Between requests the bench drives random values on all inputs while `reqValid` is low, to exercise the hold behaviour.

// File: rtl/bru_pkg.sv
package bru_pkg;
  parameter int PC_W       = 24;
  parameter int OFS_W      = 16;
  parameter int DISP_W     = 8;
  parameter int PAGE_SHIFT = 8;
  parameter int CYC_W      = 2;
  parameter int STEP       = 2;
  localparam int BANK_W    = PC_W - OFS_W;
  localparam int PAGE_W    = OFS_W - PAGE_SHIFT;

  typedef struct packed {
    logic capture;
    logic hold;
  } bruStrobes_t;
endpackage

// File: rtl/bru_ctrl.sv
module bru_ctrl
  import bru_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output bruStrobes_t strobes,
  output logic        outValid
);
  always_comb begin
    strobes.capture = reqValid;
    strobes.hold    = !reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= reqValid;
  end
endmodule

// File: rtl/bru_datapath.sv
module bru_datapath
  import bru_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bruStrobes_t       strobes,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [DISP_W-1:0] dispIn,
  input  logic              condTrue,
  input  logic              emuMode,
  output logic [PC_W-1:0]   nextPc,
  output logic [CYC_W-1:0]  extraCycles
);
  logic [BANK_W-1:0] bank;
  logic [OFS_W-1:0]  seqOfs;
  logic [OFS_W-1:0]  dispExt;
  logic [OFS_W-1:0]  tgtOfs;
  logic              pageCross;
  logic [CYC_W-1:0]  cycNext;

  // sign extension of the displacement to the offset width
  generate
    if (OFS_W > DISP_W) begin : g_sext
      assign dispExt = {{(OFS_W-DISP_W){dispIn[DISP_W-1]}}, dispIn};
    end else begin : g_nosext
      assign dispExt = dispIn[OFS_W-1:0];
    end
  endgenerate

  always_comb begin
    bank      = pcIn[PC_W-1:OFS_W];
    seqOfs    = pcIn[OFS_W-1:0] + OFS_W'(STEP);
    tgtOfs    = condTrue ? (seqOfs + dispExt) : seqOfs;
    pageCross = seqOfs[OFS_W-1:PAGE_SHIFT] != tgtOfs[OFS_W-1:PAGE_SHIFT];
    if (!condTrue)                 cycNext = CYC_W'(0);
    else if (emuMode && pageCross) cycNext = CYC_W'(2);
    else                           cycNext = CYC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc      <= '0;
      extraCycles <= '0;
    end else if (strobes.capture && !strobes.hold) begin
      nextPc      <= {bank, tgtOfs};
      extraCycles <= cycNext;
    end
  end
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import bru_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              condTrue,
  input  logic              emuMode,
  output logic              outValid,
  output logic [PC_W-1:0]   nextPc,
  output logic [CYC_W-1:0]  extraCycles
);
  bruStrobes_t strobes;

  bru_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  bru_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pcIn        (pc),
    .dispIn      (disp),
    .condTrue    (condTrue),
    .emuMode     (emuMode),
    .nextPc      (nextPc),
    .extraCycles (extraCycles)
  );
endmodule

// File: rtl/rel_branch_unit_checker.sv
module rel_branch_unit_checker
  import bru_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [PC_W-1:0]   pc,
  input logic              condTrue,
  input logic              emuMode,
  input logic              outValid,
  input logic [PC_W-1:0]   nextPc,
  input logic [CYC_W-1:0]  extraCycles
);
  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!outValid && nextPc == '0 && extraCycles == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  a_r3_untaken: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !condTrue) |=>
      (extraCycles == '0 &&
       nextPc[OFS_W-1:0] == OFS_W'($past(pc[OFS_W-1:0]) + OFS_W'(STEP))));

  a_r5_taken_costs: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && condTrue) |=> (extraCycles != '0));

  a_r6_native_single: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !emuMode) |=> (extraCycles != CYC_W'(2)));

  a_r7_bank_kept: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (nextPc[PC_W-1:OFS_W] == $past(pc[PC_W-1:OFS_W])));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(nextPc) && $stable(extraCycles)));
endmodule

bind rel_branch_unit rel_branch_unit_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .pc          (pc),
  .condTrue    (condTrue),
  .emuMode     (emuMode),
  .outValid    (outValid),
  .nextPc      (nextPc),
  .extraCycles (extraCycles)
);

// File: tb/rel_branch_unit_test.sv
module rel_branch_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [23:0] pc = '0;
  logic [7:0]  disp = '0;
  logic        condTrue = 1'b0;
  logic        emuMode = 1'b0;
  logic        outValid;
  logic [23:0] nextPc;
  logic [1:0]  extraCycles;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rel_branch_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pc(pc), .disp(disp),
    .condTrue(condTrue), .emuMode(emuMode), .outValid(outValid),
    .nextPc(nextPc), .extraCycles(extraCycles)
  );

  function automatic logic [23:0] expPc(logic [23:0] p, logic [7:0] d, logic c);
    int seq = (int'(p) & 32'hFFFF) + 2;
    int sd  = (d >= 8'h80) ? int'(d) - 256 : int'(d);
    int tgt = c ? seq + sd : seq;
    return {p[23:16], 16'(tgt & 32'hFFFF)};
  endfunction

  function automatic logic [1:0] expCyc(logic [23:0] p, logic [7:0] d, logic c, logic e);
    int seq = ((int'(p) & 32'hFFFF) + 2) & 32'hFFFF;
    int sd  = (d >= 8'h80) ? int'(d) - 256 : int'(d);
    int tgt = (seq + sd) & 32'hFFFF;
    if (!c) return 2'd0;
    if (e && ((seq >> 8) != (tgt >> 8))) return 2'd2;
    return 2'd1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request; outputs checked at the following falling edge
  task automatic branch(logic [23:0] p, logic [7:0] d, logic c, logic e, string req);
    logic [23:0] ePc = expPc(p, d, c);
    logic [1:0]  eCy = expCyc(p, d, c, e);
    @(negedge clk);
    pc = p; disp = d; condTrue = c; emuMode = e; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " R2 valid"}, 32'(outValid), 32'd1);
    check({req, " pc"}, 32'(nextPc), 32'(ePc));
    check({req, " cycles"}, 32'(extraCycles), 32'(eCy));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] heldPc;
    logic [1:0]  heldCy;
    int unused;
    unused = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(outValid), 32'd0);
    check("R1 pc", 32'(nextPc), 32'd0);
    check("R1 cycles", 32'(extraCycles), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'(nextPc), 32'd0);

    branch(24'h120040, 8'h10, 1'b0, 1'b1, "R3 untaken");
    branch(24'h12FFFE, 8'h05, 1'b0, 1'b0, "R3 R7 untaken wrap");
    branch(24'h12FFFE, 8'h05, 1'b1, 1'b1, "R4 R7 taken wrap");
    branch(24'h340000, 8'hF0, 1'b1, 1'b1, "R6 R7 negative wrap emu");
    branch(24'h340000, 8'hF0, 1'b1, 1'b0, "R5 negative wrap native");
    branch(24'h0010FE, 8'h7F, 1'b1, 1'b1, "R5 same page emu");
    branch(24'h0010F0, 8'h20, 1'b1, 1'b1, "R6 cross forward emu");
    branch(24'h0010F0, 8'h20, 1'b1, 1'b0, "R5 cross forward native");
    branch(24'hAB2000, 8'h80, 1'b1, 1'b1, "R4 R6 min disp");

    // back-to-back requests
    @(negedge clk);
    pc = 24'h5600FE; disp = 8'h01; condTrue = 1'b1; emuMode = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    check("R2 b2b first pc", 32'(nextPc), 32'(expPc(24'h5600FE, 8'h01, 1'b1)));
    check("R6 b2b first cycles", 32'(extraCycles), 32'(expCyc(24'h5600FE, 8'h01, 1'b1, 1'b1)));
    pc = 24'h560010; disp = 8'hFE; condTrue = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 b2b second valid", 32'(outValid), 32'd1);
    check("R3 b2b second pc", 32'(nextPc), 32'h560012);

    // hold: random inputs without a request
    heldPc = nextPc; heldCy = extraCycles;
    for (int i = 0; i < 5; i++) begin
      pc = 24'($urandom); disp = 8'($urandom); condTrue = 1'($urandom);
      emuMode = 1'($urandom);
      @(negedge clk);
      check("R2 idle valid", 32'(outValid), 32'd0);
      check("R8 hold pc", 32'(nextPc), 32'(heldPc));
      check("R8 hold cycles", 32'(extraCycles), 32'(heldCy));
    end

    // random requests biased towards page and bank edges
    for (int i = 0; i < 300; i++) begin
      logic [23:0] p = 24'($urandom);
      if (($urandom % 3) == 0) p[7:0] = 8'hF0 | 8'($urandom % 16);
      if (($urandom % 5) == 0) p[15:8] = 8'hFF;
      branch(p, 8'($urandom), 1'($urandom), 1'($urandom), "R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule